// File: doc/BRIEF.md
# RTC Alarm Match Unit

This block keeps a 32-bit alarm target and compares it with the external seconds counter once per tick of a 1 Hz timebase. When the target equals the counter at a tick and the alarm is enabled, a sticky alarm flag is raised. The flag stays up until software clears it by writing a one.

Target writes arrive from a fast bus clock. The write data is held in the bus domain, and a toggle request crosses into the slow (32 kHz) domain through two flops. The slow domain commits the held data to the target two slow-clock edges after the store. A busy output stays high from the store until the acknowledge has returned to the bus domain. A further write while busy only replaces the held data. Reads always return the committed target.

The 1 Hz timebase is sampled in the slow domain, and the compare acts only on its rising edge. The seconds counter and interrupt routing belong to neighbouring blocks.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the committed target (`rdData`) is 0x00000000, `alarmFlag` is 0 and `busy` is 0.
- R2: A store (`wrEn` high at a rising `busClk` edge) reaches `rdData` at the second rising `slowClk` edge after the store. After the first such edge, `rdData` still shows the previous committed value.
- R3: `busy` is 1 from the `busClk` edge of a store until the commit has been acknowledged back in the bus domain. It is 0 again well before the next `slowClk` edge after the commit.
- R4: A store made while `busy` is 1 starts no new transfer. It replaces the held data, so the value committed is the last one written.
- R5: On a `slowClk` edge where `hzTick` is sampled 1 after being sampled 0 on the previous edge, `alarmFlag` becomes 1 if `alarmEn` is 1 and the target equals `secCount`.
- R6: `alarmFlag` does not rise at a tick when `alarmEn` is 0 or when the target differs from `secCount`.
- R7: `alarmFlag` is sticky. It stays 1 across later ticks that do not match, and only `alarmClr` sampled 1 at a `slowClk` edge clears it.
- R8: When a matching enabled tick and `alarmClr` fall on the same `slowClk` edge, the flag is set.
- R9: While `hzTick` stays high, no further compare takes place, even when target and counter match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Fast bus clock |
| busRstN | input | 1 | Active-low asynchronous reset, bus domain |
| wrEn | input | 1 | Target write strobe, one bus cycle per store |
| wrData | input | 32 | Target write data |
| rdData | output | 32 | Committed target value |
| busy | output | 1 | A target write is still crossing |
| slowClk | input | 1 | 32 kHz clock |
| slowRstN | input | 1 | Active-low asynchronous reset, slow domain |
| hzTick | input | 1 | 1 Hz timebase, sampled on slowClk |
| secCount | input | 32 | Seconds counter value, slowClk domain |
| alarmEn | input | 1 | Alarm enable |
| alarmClr | input | 1 | Write-one-to-clear for the alarm flag |
| alarmFlag | output | 1 | Sticky alarm status |

## Verification
The assertions assume that `hzTick`, `secCount`, `alarmEn` and `alarmClr` are synchronous to `slowClk`. They also assume that the held write data does not change near the slow edge that commits it. The single-commit check further relies on no new transfer starting before the acknowledge returns. The stimulus changes slow-domain inputs only on falling `slowClk` edges. It issues bus writes on falling `busClk` edges, and the slow clock is offset so that no edge of the two clocks coincides. Back-to-back writes are kept inside the window that comes before the committing edge.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic holdLoad; // bus domain: capture write data
    logic commit;   // slow domain: move held data into the target
    logic hzRise;   // slow domain: rising edge of the 1 Hz tick
  } ctrlStrobes_t;
endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int BACK_SYNC = 2
) (
  input  logic         busClk,
  input  logic         busRstN,
  input  logic         wrEn,
  output logic         busy,
  input  logic         slowClk,
  input  logic         slowRstN,
  input  logic         hzTick,
  output ctrlStrobes_t strb
);
  localparam int LAST = BACK_SYNC - 1;

  logic reqToggle;
  logic [LAST:0] ackSync;
  logic reqS1, ackToggle, hzPrev;

  // bus side: a new request only when idle
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      reqToggle <= 1'b0;
      ackSync   <= '0;
    end else begin
      if (wrEn && !busy) reqToggle <= ~reqToggle;
      ackSync <= {ackSync[LAST-1:0], ackToggle};
    end
  end

  assign busy = reqToggle ^ ackSync[LAST];

  // slow side: reqS1 is the first stage, ackToggle the second
  always_ff @(posedge slowClk or negedge slowRstN) begin
    if (!slowRstN) begin
      reqS1     <= 1'b0;
      ackToggle <= 1'b0;
      hzPrev    <= 1'b0;
    end else begin
      reqS1     <= reqToggle;
      ackToggle <= reqS1;
      hzPrev    <= hzTick;
    end
  end

  always_comb begin
    strb.holdLoad = wrEn;
    strb.commit   = reqS1 ^ ackToggle;
    strb.hzRise   = hzTick & ~hzPrev;
  end

  // R3: a store always leaves the block busy on the next bus edge
  a_r3_busy_after_store: assert property (@(posedge busClk) disable iff (!busRstN)
    wrEn |=> busy);

  // R2: one store gives exactly one commit strobe
  a_r2_single_commit: assert property (@(posedge slowClk) disable iff (!slowRstN)
    strb.commit |=> !strb.commit);

  // R9: the tick edge strobe never lasts two slow cycles
  a_r9_rise_once: assert property (@(posedge slowClk) disable iff (!slowRstN)
    strb.hzRise |=> !strb.hzRise);
endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              slowClk,
  input  logic              slowRstN,
  input  logic [DATA_W-1:0] secCount,
  input  logic              alarmEn,
  input  logic              alarmClr,
  input  ctrlStrobes_t      strb,
  output logic [DATA_W-1:0] target,
  output logic              alarmFlag
);
  logic [DATA_W-1:0] holdData;
  logic hit;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN)          holdData <= '0;
    else if (strb.holdLoad) holdData <= wrData;
  end

  assign hit = strb.hzRise && alarmEn && (target == secCount);

  always_ff @(posedge slowClk or negedge slowRstN) begin
    if (!slowRstN) begin
      target    <= '0;
      alarmFlag <= 1'b0;
    end else begin
      if (strb.commit) target <= holdData;
      if (hit)           alarmFlag <= 1'b1;
      else if (alarmClr) alarmFlag <= 1'b0;
    end
  end

  // R2: the target moves only on a commit strobe
  a_r2_target_hold: assert property (@(posedge slowClk) disable iff (!slowRstN)
    !strb.commit |=> $stable(target));

  // R7: the flag survives every edge without a clear
  a_r7_sticky: assert property (@(posedge slowClk) disable iff (!slowRstN)
    alarmFlag && !alarmClr |=> alarmFlag);

  // R6: the flag only rises after an enabled tick edge
  a_r6_rise_cause: assert property (@(posedge slowClk) disable iff (!slowRstN)
    $rose(alarmFlag) |-> $past(strb.hzRise && alarmEn));

  // R8: a clear on the matching edge loses
  a_r8_set_wins: assert property (@(posedge slowClk) disable iff (!slowRstN)
    strb.hzRise && alarmEn && (target == secCount) && alarmClr |=> alarmFlag);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BACK_SYNC = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  input  logic              slowClk,
  input  logic              slowRstN,
  input  logic              hzTick,
  input  logic [DATA_W-1:0] secCount,
  input  logic              alarmEn,
  input  logic              alarmClr,
  output logic              alarmFlag
);
  ctrlStrobes_t strb;

  rtc_alarm_ctrl #(.BACK_SYNC(BACK_SYNC)) u_ctrl (
    .busClk(busClk), .busRstN(busRstN), .wrEn(wrEn), .busy(busy),
    .slowClk(slowClk), .slowRstN(slowRstN), .hzTick(hzTick), .strb(strb)
  );

  rtc_alarm_dp #(.DATA_W(DATA_W)) u_dp (
    .busClk(busClk), .busRstN(busRstN), .wrData(wrData),
    .slowClk(slowClk), .slowRstN(slowRstN), .secCount(secCount),
    .alarmEn(alarmEn), .alarmClr(alarmClr), .strb(strb),
    .target(rdData), .alarmFlag(alarmFlag)
  );
endmodule

// File: tb/tb_rtc_alarm_match.sv
`timescale 1ns/1ps
module tb_rtc_alarm_match;
  logic busClk = 1'b0, slowClk = 1'b0;
  logic busRstN = 1'b0, slowRstN = 1'b0;
  logic wrEn = 1'b0, hzTick = 1'b0, alarmEn = 1'b0, alarmClr = 1'b0;
  logic [31:0] wrData = '0, secCount = '0;
  logic [31:0] rdData;
  logic busy, alarmFlag;

  int total = 0, failed = 0;
  bit finished = 0;

  typedef struct { string req; int sig; logic [31:0] exp; } item_t;
  item_t q[$];

  always #2.5 busClk = ~busClk;   // 200 MHz
  initial begin #101; forever #100 slowClk = ~slowClk; end

  rtc_alarm_match dut (
    .busClk(busClk), .busRstN(busRstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .busy(busy), .slowClk(slowClk), .slowRstN(slowRstN),
    .hzTick(hzTick), .secCount(secCount), .alarmEn(alarmEn),
    .alarmClr(alarmClr), .alarmFlag(alarmFlag)
  );

  // scoreboard monitor: sig 0 = rdData, 1 = busy, 2 = alarmFlag
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (q.size() != 0);
      it = q.pop_front();
      act = (it.sig == 0) ? rdData : (it.sig == 1) ? {31'd0, busy} : {31'd0, alarmFlag};
      total++;
      if (act !== it.exp) begin
        failed++;
        $display("FAIL %s sig%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
      end
    end
  end

  task automatic expectNow(string req, int sig, logic [31:0] exp);
    q.push_back('{req, sig, exp});
    #0.1;
  endtask

  task automatic busWrite(logic [31:0] d);
    @(negedge busClk); wrEn = 1'b1; wrData = d;
    @(negedge busClk); wrEn = 1'b0;
  endtask

  task automatic slowStep();
    @(posedge slowClk); @(negedge slowClk);
  endtask

  task automatic tick(logic [31:0] cnt, logic en, logic clr);
    @(negedge slowClk); hzTick = 1'b1; secCount = cnt; alarmEn = en; alarmClr = clr;
    @(negedge slowClk); alarmClr = 1'b0;
  endtask

  task automatic tickLow();
    @(negedge slowClk); hzTick = 1'b0;
    @(negedge slowClk);
  endtask

  initial begin
    repeat (3) @(negedge busClk);
    busRstN = 1'b1; slowRstN = 1'b1;
    @(negedge busClk);
    expectNow("R1", 0, 32'h0);
    expectNow("R1", 1, 32'h0);
    expectNow("R1", 2, 32'h0);

    // R2/R3: single write
    busWrite(32'h1234_5678);
    expectNow("R3", 1, 32'h1);
    slowStep();
    expectNow("R2", 0, 32'h0);       // pending, not yet committed
    expectNow("R3", 1, 32'h1);
    slowStep();
    expectNow("R2", 0, 32'h1234_5678);
    expectNow("R3", 1, 32'h0);

    // R4: second write while busy replaces the held data
    @(negedge slowClk);
    @(negedge busClk); wrEn = 1'b1; wrData = 32'hAAAA_0001;
    @(negedge busClk); wrData = 32'h0000_BEEF;
    expectNow("R4", 1, 32'h1);
    @(negedge busClk); wrEn = 1'b0;
    slowStep(); slowStep();
    expectNow("R4", 0, 32'h0000_BEEF);
    expectNow("R4", 1, 32'h0);

    // R6: disabled match, then enabled mismatch
    tick(32'h0000_BEEF, 1'b0, 1'b0);
    expectNow("R6", 2, 32'h0);
    tickLow();
    tick(32'h0000_BEF0, 1'b1, 1'b0);
    expectNow("R6", 2, 32'h0);
    tickLow();

    // R5: enabled match
    tick(32'h0000_BEEF, 1'b1, 1'b0);
    expectNow("R5", 2, 32'h1);
    tickLow();

    // R7: sticky across a mismatching tick, cleared by alarmClr
    tick(32'h0000_0007, 1'b1, 1'b0);
    expectNow("R7", 2, 32'h1);
    @(negedge slowClk); alarmClr = 1'b1;
    @(negedge slowClk); alarmClr = 1'b0;
    expectNow("R7", 2, 32'h0);

    // R9: hzTick still high, now matching: no new compare
    secCount = 32'h0000_BEEF;
    slowStep();
    expectNow("R9", 2, 32'h0);
    tickLow();

    // R8: match and clear on the same edge
    tick(32'h0000_BEEF, 1'b1, 1'b1);
    expectNow("R8", 2, 32'h1);
    tickLow();

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge busClk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule